// File: doc/BRIEF.md
# FM-Synth Interval Timer and Status Unit

This block holds the two interval timers, their shared control register, the status byte and the interrupt line of a classic FM sound generator. The host uses a two-step access. It first writes a register index to the address port (`host_sel` low). It then writes a data byte to the data port (`host_sel` high), and that byte goes to the register the index selects. The status byte is presented continuously on `status`, which is the value the host reads from the address port.

Each timer is an 8-bit up-counter with its own preload register. When the timer is started, the counter loads from the preload. The counter advances once per tick, and on passing 0xFF it overflows, reloads from the preload and keeps counting. Software therefore loads 256 minus the number of ticks it wants. Timer 1 ticks every `T1_US` microseconds and timer 2 every `T2_US` microseconds. Both periods come from the system clock through per-timer prescalers sized by `CLK_HZ`. An overflow raises the timer's status flag, unless the timer's mask bit is set. Either raised flag drives the interrupt.

Top module: `fm_timer_unit`

## Requirements
- R1: After reset, `status` is 0x00 and `irq` is low.
- R2: A data-port write goes to the register named by the most recent address-port write. Index 0x02 is the timer 1 preload, 0x03 is the timer 2 preload and 0x04 is control. A data write under any other index changes nothing.
- R3: Control bit 0 starts timer 1. If timer 1 is started with preload P and mask clear, status bits 7 and 6 rise exactly (256-P)*DIV1 clock cycles after the control write takes effect, where DIV1 = CLK_HZ/1e6*T1_US. Example: preload 0xFF with control 0x21 gives status 0xC0 after DIV1 cycles.
- R4: Control bit 1 starts timer 2. If timer 2 is started with preload P, status bits 7 and 5 rise exactly (256-P)*DIV2 cycles after the write, where DIV2 = CLK_HZ/1e6*T2_US.
- R5: Control bit 6 masks timer 1 and bit 5 masks timer 2. A masked timer's overflow sets no flag, but the timer keeps counting in phase.
- R6: On overflow, a running timer reloads its preload and overflows again after a further (256-P) ticks, without any host access.
- R7: A control write with bit 7 set clears all status flags in the following cycle. It leaves the start and mask bits, and the timers, unchanged.
- R8: A timer whose start bit is clear holds its count and raises no flag.
- R9: `irq` equals status bit 7 at all times. Status bit 7 is the OR of bits 6 and 5, and bits 4 to 0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | 0 selects the address (index) port, 1 selects the data port |
| host_wdata | input | 8 | Write data |
| status | output | 8 | Status byte: bit 7 IRQ, bit 6 timer 1, bit 5 timer 2 |
| irq | output | 1 | Interrupt request, active high |

## Verification
Timer 1 is first started from preload 0xFF. This shows that a single tick is enough for an overflow, and that the flag lands on the exact cycle. The run continues through a flag clear, which separates a timer that keeps its phase from one restarted by the clear. Timer 2 is run from preload 0xFE after a data write under an unmapped index. This separates the two prescaler periods and shows that multi-tick counting works and that stray writes have no effect. A masked timer is then unmasked while it runs. The bench checks that its first flag falls on the original tick grid, which distinguishes a timer that counts while masked from one that stalls.

// File: rtl/fm_timer_unit.sv
module fm_timer_unit #(
  parameter int CLK_HZ = 50_000_000,
  parameter int T1_US  = 80,
  parameter int T2_US  = 320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] status,
  output logic       irq
);
  localparam int DIV1 = CLK_HZ / 1_000_000 * T1_US;
  localparam int DIV2 = CLK_HZ / 1_000_000 * T2_US;
  localparam int PW   = $clog2(DIV2 + 1);
  localparam logic [7:0] IDX_T1  = 8'h02;
  localparam logic [7:0] IDX_T2  = 8'h03;
  localparam logic [7:0] IDX_CTL = 8'h04;

  logic [7:0]      idx;
  logic [1:0]      run, mask, flag, tick;
  logic [1:0][7:0] cnt, pre;

  wire       data_wr  = host_wr & host_sel;
  wire       ctl_wr   = data_wr && (idx == IDX_CTL);
  wire       flag_clr = ctl_wr & host_wdata[7];
  wire       ctl_set  = ctl_wr & ~host_wdata[7];
  wire [1:0] nxt_run  = ctl_set ? {host_wdata[1], host_wdata[0]} : run;
  wire [1:0] nxt_mask = ctl_set ? {host_wdata[5], host_wdata[6]} : mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      run  <= '0;
      mask <= '0;
    end else begin
      if (host_wr && !host_sel) idx <= host_wdata;
      run  <= nxt_run;
      mask <= nxt_mask;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    localparam int D = (i == 0) ? DIV1 : DIV2;
    localparam logic [7:0] MY_IDX = (i == 0) ? IDX_T1 : IDX_T2;
    logic [7:0]    cnt_r, pre_r;
    logic [PW-1:0] ps_r;
    logic          flag_r;
    wire launch = nxt_run[i] & ~run[i];
    wire tck    = run[i] && (ps_r == PW'(D - 1));
    wire ovf    = tck && (cnt_r == 8'hFF);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_r  <= '0;
        pre_r  <= '0;
        ps_r   <= '0;
        flag_r <= 1'b0;
      end else begin
        if (data_wr && idx == MY_IDX) pre_r <= host_wdata;
        if (launch) begin
          ps_r  <= '0;
          cnt_r <= pre_r;
        end else if (run[i]) begin
          ps_r <= tck ? '0 : ps_r + 1'b1;
          if (tck) cnt_r <= ovf ? pre_r : cnt_r + 8'd1;
        end
        if (flag_clr)              flag_r <= 1'b0;
        else if (ovf && !mask[i])  flag_r <= 1'b1;
      end
    end

    assign cnt[i]  = cnt_r;
    assign pre[i]  = pre_r;
    assign flag[i] = flag_r;
    assign tick[i] = tck;
  end

  assign irq    = |flag;
  assign status = {irq, flag[0], flag[1], 5'b0};
endmodule

// File: rtl/fm_timer_unit_chk.sv
module fm_timer_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_sel,
  input logic [7:0] host_wdata,
  input logic [7:0] status,
  input logic [7:0] idx,
  input logic [1:0] run,
  input logic [1:0] mask,
  input logic [1:0] tick,
  input logic [7:0] cnt0,
  input logic [7:0] pre0
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> status == 8'h00);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && idx == 8'h04 && host_wdata[7]) |=> status[7:5] == 3'b000);

  p_flag_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(run[0] && !mask[0]));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !host_wr) |=> $stable(cnt0));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick[0] && cnt0 == 8'hFF && !host_wr) |=> cnt0 == $past(pre0));
endmodule

bind fm_timer_unit fm_timer_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .status(status), .idx(idx), .run(run),
  .mask(mask), .tick(tick), .cnt0(cnt[0]), .pre0(pre[0])
);

// File: tb/test_fm_timer_unit.sv
`timescale 1ns/1ps
module test_fm_timer_unit;
  localparam int CLK_HZ = 1_000_000;
  localparam int D1 = 80;
  localparam int D2 = 320;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] status;
  logic       irq;

  fm_timer_unit #(.CLK_HZ(CLK_HZ), .T1_US(80), .T2_US(320)) i_fm_timer_unit (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .status(status), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // behavioural reference model
  int m_idx, m_pre[2], m_cnt[2], m_ps[2], m_run[2], m_mask[2], m_flag[2];
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_idx = 0;
      for (int t = 0; t < 2; t++) begin
        m_pre[t] = 0; m_cnt[t] = 0; m_ps[t] = 0; m_run[t] = 0; m_mask[t] = 0; m_flag[t] = 0;
      end
    end else begin
      int nr[2], nm[2], clr, div, ovf;
      clr = 0;
      nr = m_run; nm = m_mask;
      if (host_wr && host_sel && m_idx == 4) begin
        if (host_wdata[7]) clr = 1;
        else begin
          nr[0] = host_wdata[0]; nr[1] = host_wdata[1];
          nm[0] = host_wdata[6]; nm[1] = host_wdata[5];
        end
      end
      for (int t = 0; t < 2; t++) begin
        div = (t == 0) ? D1 : D2;
        ovf = 0;
        if (nr[t] == 1 && m_run[t] == 0) begin
          m_ps[t] = 0; m_cnt[t] = m_pre[t];
        end else if (m_run[t] == 1) begin
          if (m_ps[t] == div - 1) begin
            m_ps[t] = 0;
            if (m_cnt[t] == 255) begin ovf = 1; m_cnt[t] = m_pre[t]; end
            else m_cnt[t] = m_cnt[t] + 1;
          end else m_ps[t] = m_ps[t] + 1;
        end
        if (clr == 1) m_flag[t] = 0;
        else if (ovf == 1 && m_mask[t] == 0) m_flag[t] = 1;
      end
      m_run = nr; m_mask = nm;
      if (host_wr && host_sel && m_idx == 2) m_pre[0] = host_wdata;
      if (host_wr && host_sel && m_idx == 3) m_pre[1] = host_wdata;
      if (host_wr && !host_sel) m_idx = host_wdata;
    end
  end

  function automatic logic [7:0] m_status();
    logic any;
    any = (m_flag[0] != 0) || (m_flag[1] != 0);
    return {any, m_flag[0] != 0, m_flag[1] != 0, 5'b0};
  endfunction

  // per-clock comparison against the model (R9 for irq, others through status)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (status !== m_status()) begin
        n_fail++;
        $display("FAIL model R3/R4/R5/R6/R7/R8 cyc %0d: status %h expected %h", cyc, status, m_status());
      end
      n_chk++;
      if (irq !== status[7] || status[4:0] !== 5'b0) begin
        n_fail++;
        $display("FAIL R9 cyc %0d: irq %b status %h expected irq==bit7, low bits 0", cyc, irq, status);
      end
    end
  end

  task automatic chk(input logic [7:0] exp, input string req);
    n_chk++;
    if (status !== exp) begin
      n_fail++;
      $display("FAIL %s: status %h expected %h", req, status, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); #1;
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic wait_bit(input int b, output int at);
    at = -1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (status[b]) begin at = cyc; break; end
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int t0, at;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(8'h00, "R1 reset status");
    chk_int(irq, 0, "R1 reset irq");

    // R3: timer 1 preload FF, timer 2 masked
    wr(0, 8'h02); wr(1, 8'hFF);
    wr(0, 8'h04); wr(1, 8'h21);
    t0 = cyc;
    repeat (D1 - 1) @(negedge clk);
    chk(8'h00, "R3 before first tick");
    @(negedge clk);
    chk(8'hC0, "R3 flag on exact tick");
    chk_int(irq, 1, "R9 irq with flag");

    // R7: clear flags, timer keeps phase; R6 periodic reload
    wr(1, 8'h80);
    chk(8'h00, "R7 flags cleared");
    wait_bit(6, at);
    chk_int(at - t0, 2 * D1, "R6 R7 next overflow keeps phase");

    // R8: stop both, no flags
    wr(1, 8'h60); wr(1, 8'h80);
    repeat (400) @(negedge clk);
    chk(8'h00, "R8 stopped timers raise no flag");

    // R2: stray write under unmapped index, then timer 2 via index 03
    wr(0, 8'h05); wr(1, 8'h01);
    wr(0, 8'h03); wr(1, 8'hFE);
    wr(0, 8'h04); wr(1, 8'h02);
    t0 = cyc;
    repeat (2 * D2 - 1) @(negedge clk);
    chk(8'h00, "R4 before second tick");
    @(negedge clk);
    chk(8'hA0, "R4 R2 timer 2 flag on exact cycle");

    // R5: masked timer 1 counts silently, then unmask in phase
    wr(1, 8'h80);
    wr(0, 8'h02); wr(1, 8'hFF);
    wr(0, 8'h04); wr(1, 8'h41);
    t0 = cyc;
    repeat (3 * D1 + 17) @(negedge clk);
    chk(8'h00, "R5 masked overflow sets no flag");
    wr(1, 8'h01);
    wait_bit(6, at);
    chk_int((at - t0) % D1, 0, "R5 unmasked flag on original tick grid");
    chk(8'hC0, "R5 flag after unmask");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule